// File: doc/BRIEF.md
# Mode Entry Sequence Detector

This block sits behind the serial control pins of a constant-current LED driver. It works in the system clock domain. A one-cycle strobe marks each rising edge of the serial clock, and on each strobe the block samples the output-enable pin and the latch pin. It keeps a sliding window of the last five samples. One fixed five-step pattern moves the block into a configuration mode, and a second pattern brings it back to the display mode.

The latch pin is steered according to the mode. In display mode a latch pulse copies the shift register contents into the display data register. In configuration mode the same pulse writes the brightness fields instead: a range-select bit and a six-bit step value. Those fields drive an external current reference, and the block also presents the resulting gain as a code in units of 1/256. Any latch pulse that forms the fourth step of the entry pattern is blocked from both destinations. Leaving configuration mode clears the display data.

Top module: `mode_seq_top`

## Requirements
- R1: After reset the block is in display mode (`mode_special`=0), `disp_data` is 0, `bright_hc` is 1, `bright_ag` is all ones and `gain_code` is 254.
- R2: Five consecutive strobes that sample `en_pin` as 1,0,1,1,1 and `latch_pin` as 0,0,0,1,0 set `mode_special` on the clock edge of the fifth strobe.
- R3: Five consecutive strobes that sample `en_pin` as 1,0,1,1,1 and `latch_pin` as 0,0,0,0,0 clear `mode_special` when it is set, and on that same edge `disp_data` becomes 0.
- R4: A strobe with `latch_pin`=1 whose `en_pin` value, together with the three samples before it, reads 1,0,1,1 while those three prior `latch_pin` samples are 0 loads neither `disp_data` nor the brightness fields.
- R5: In display mode, a strobe with `latch_pin`=1 (not blocked by R4) raises `load_display` in that cycle and copies `shift_data` into `disp_data` at the following edge.
- R6: In configuration mode, a strobe with `latch_pin`=1 (not blocked by R4) raises `load_bright` and leaves `disp_data` unchanged. `bright_hc` takes `shift_data[1]`, `bright_ag[5-j]` takes `shift_data[2+j]` for j=0..5 (the first serial bit becomes AG bit 0), and `shift_data[0]` is ignored.
- R7: `gain_code` equals 128+2*`bright_ag` when `bright_hc`=1 (50 % to 99 % range) and 64+`bright_ag` when `bright_hc`=0 (25 % to 49 % range).
- R8: Cycles without `smp_stb` neither load anything nor enter the window. A five-sample sequence that differs from a pattern in any sample leaves the mode unchanged, and the window keeps sliding.
- R9: The brightness fields keep their value across mode changes until a configuration-mode latch pulse overwrites them.
- R10: The exit pattern, when seen in display mode, leaves both `mode_special` and `disp_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_stb | input | 1 | One-cycle strobe marking a serial-clock rising edge |
| en_pin | input | 1 | Sampled output-enable pin level |
| latch_pin | input | 1 | Sampled latch pin level |
| shift_data | input | 8 | Parallel contents of the external shift register |
| mode_special | output | 1 | 1 while in configuration mode |
| load_display | output | 1 | Latch pulse steered to the display register (this cycle) |
| load_bright | output | 1 | Latch pulse steered to the brightness register (this cycle) |
| disp_data | output | 8 | Display data register |
| bright_hc | output | 1 | Range-select bit |
| bright_ag | output | 6 | Step value within the range |
| gain_code | output | 8 | Resulting gain in 1/256 units |

## Verification
From the ports, the hardest situation to reach is the fourth strobe of the entry pattern. There the latch pin is high, but the load must be blocked before the block can know that a fifth matching sample will follow. The bench drives that strobe with distinctive data, and it interleaves non-strobe cycles that toggle both pins to show that only strobes count. It also runs a near miss whose fourth sample differs only in the enable level, so there the load must happen. For the gain mapping, every combination of range bit and step value is loaded through the latch path in configuration mode, with the reserved bit flipped along the way, and each result is compared with an arithmetic formula.

// File: rtl/mode_seq_pkg.sv
package mode_seq_pkg;
  typedef enum logic {
    OPM_DISPLAY = 1'b0,
    OPM_CONFIG  = 1'b1
  } op_mode_e;

  // Pattern bit SEQ_LEN-1 is the oldest sample (first strobe)
  localparam int unsigned SEQ_LEN_DEF   = 5;
  localparam logic [4:0]  ENTRY_EN_DEF  = 5'b10111;
  localparam logic [4:0]  ENTRY_LT_DEF  = 5'b00010;
  localparam logic [4:0]  EXIT_EN_DEF   = 5'b10111;
  localparam logic [4:0]  EXIT_LT_DEF   = 5'b00000;
endpackage

// File: rtl/mode_seq_hist.sv
module mode_seq_hist #(
  parameter int unsigned SEQ_LEN = 5,
  parameter logic [SEQ_LEN-1:0] ENTRY_EN = '1,
  parameter logic [SEQ_LEN-1:0] ENTRY_LT = '0,
  parameter logic [SEQ_LEN-1:0] EXIT_EN  = '1,
  parameter logic [SEQ_LEN-1:0] EXIT_LT  = '0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stb,
  input  logic en_now,
  input  logic lt_now,
  output logic hit_entry,
  output logic hit_exit,
  output logic hit_entry_pre
);
  localparam int unsigned HW = SEQ_LEN - 1;

  logic [HW-1:0] hist_en_q, hist_en_d;
  logic [HW-1:0] hist_lt_q, hist_lt_d;

  // next-state: each stage takes its younger neighbour on a strobe
  genvar g;
  generate
    for (g = 0; g < HW; g++) begin : g_stage
      if (g == 0) begin : g_head
        always_comb begin
          hist_en_d[g] = stb ? en_now : hist_en_q[g];
          hist_lt_d[g] = stb ? lt_now : hist_lt_q[g];
        end
      end else begin : g_body
        always_comb begin
          hist_en_d[g] = stb ? hist_en_q[g-1] : hist_en_q[g];
          hist_lt_d[g] = stb ? hist_lt_q[g-1] : hist_lt_q[g];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_en_q <= '0;
      hist_lt_q <= '0;
    end else begin
      hist_en_q <= hist_en_d;
      hist_lt_q <= hist_lt_d;
    end
  end

  logic [SEQ_LEN-1:0] win_en, win_lt;
  always_comb begin
    win_en = {hist_en_q, en_now};
    win_lt = {hist_lt_q, lt_now};
    hit_entry     = stb && (win_en == ENTRY_EN) && (win_lt == ENTRY_LT);
    hit_exit      = stb && (win_en == EXIT_EN)  && (win_lt == EXIT_LT);
    hit_entry_pre = stb && (win_en[SEQ_LEN-2:0] == ENTRY_EN[SEQ_LEN-1:1])
                        && (win_lt[SEQ_LEN-2:0] == ENTRY_LT[SEQ_LEN-1:1]);
  end
endmodule

// File: rtl/mode_seq_ctrl.sv
module mode_seq_ctrl
  import mode_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic stb,
  input  logic lt_now,
  input  logic hit_entry,
  input  logic hit_exit,
  input  logic hit_entry_pre,
  output logic mode_special,
  output logic load_disp,
  output logic load_bright,
  output logic clear_disp
);
  op_mode_e mode_q, mode_d;
  logic     latch_ok;

  always_comb begin
    mode_d = mode_q;
    if (hit_entry)     mode_d = OPM_CONFIG;
    else if (hit_exit) mode_d = OPM_DISPLAY;
  end

  always_comb begin
    latch_ok    = stb && lt_now && !hit_entry_pre;
    load_disp   = latch_ok && (mode_q == OPM_DISPLAY);
    load_bright = latch_ok && (mode_q == OPM_CONFIG);
    clear_disp  = hit_exit && (mode_q == OPM_CONFIG);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= OPM_DISPLAY;
    else        mode_q <= mode_d;
  end

  assign mode_special = (mode_q == OPM_CONFIG);
endmodule

// File: rtl/mode_bright_reg.sv
module mode_bright_reg #(
  parameter int unsigned AG_W = 6,
  localparam int unsigned DW = AG_W + 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [DW-1:1]   code,
  output logic            hc,
  output logic [AG_W-1:0] ag,
  output logic [DW-1:0]   gain
);
  logic [AG_W-1:0] ag_map;
  logic            hc_q, hc_d;
  logic [AG_W-1:0] ag_q, ag_d;

  // first serial bit (code MSB) lands in AG bit 0
  genvar k;
  generate
    for (k = 0; k < AG_W; k++) begin : g_fld
      assign ag_map[k] = code[DW-1-k];
    end
  endgenerate

  always_comb begin
    hc_d = load ? code[1] : hc_q;
    ag_d = load ? ag_map  : ag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hc_q <= 1'b1;
      ag_q <= '1;
    end else begin
      hc_q <= hc_d;
      ag_q <= ag_d;
    end
  end

  always_comb begin
    if (hc_q) gain = DW'(1 << (AG_W + 1)) + {1'b0, ag_q, 1'b0};
    else      gain = DW'(1 << AG_W) + {2'b00, ag_q};
  end

  assign hc = hc_q;
  assign ag = ag_q;
endmodule

// File: rtl/mode_disp_reg.sv
module mode_disp_reg #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          clear,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  logic [DW-1:0] q, d;

  always_comb begin
    d = q;
    if (clear)     d = '0;
    else if (load) d = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end

  assign dout = q;
endmodule

// File: rtl/mode_seq_top.sv
module mode_seq_top
  import mode_seq_pkg::*;
#(
  parameter int unsigned AG_W = 6,
  localparam int unsigned DATA_W = AG_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_stb,
  input  logic              en_pin,
  input  logic              latch_pin,
  input  logic [DATA_W-1:0] shift_data,
  output logic              mode_special,
  output logic              load_display,
  output logic              load_bright,
  output logic [DATA_W-1:0] disp_data,
  output logic              bright_hc,
  output logic [AG_W-1:0]   bright_ag,
  output logic [DATA_W-1:0] gain_code
);
  logic hit_entry, hit_exit, hit_pre, clear_disp;

  mode_seq_hist #(
    .SEQ_LEN (SEQ_LEN_DEF),
    .ENTRY_EN(ENTRY_EN_DEF),
    .ENTRY_LT(ENTRY_LT_DEF),
    .EXIT_EN (EXIT_EN_DEF),
    .EXIT_LT (EXIT_LT_DEF)
  ) u_hist (
    .clk          (clk),
    .rst_n        (rst_n),
    .stb          (smp_stb),
    .en_now       (en_pin),
    .lt_now       (latch_pin),
    .hit_entry    (hit_entry),
    .hit_exit     (hit_exit),
    .hit_entry_pre(hit_pre)
  );

  mode_seq_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .stb          (smp_stb),
    .lt_now       (latch_pin),
    .hit_entry    (hit_entry),
    .hit_exit     (hit_exit),
    .hit_entry_pre(hit_pre),
    .mode_special (mode_special),
    .load_disp    (load_display),
    .load_bright  (load_bright),
    .clear_disp   (clear_disp)
  );

  mode_bright_reg #(.AG_W(AG_W)) u_bright (
    .clk  (clk),
    .rst_n(rst_n),
    .load (load_bright),
    .code (shift_data[DATA_W-1:1]),
    .hc   (bright_hc),
    .ag   (bright_ag),
    .gain (gain_code)
  );

  mode_disp_reg #(.DW(DATA_W)) u_disp (
    .clk  (clk),
    .rst_n(rst_n),
    .load (load_display),
    .clear(clear_disp),
    .din  (shift_data),
    .dout (disp_data)
  );
endmodule

// File: rtl/mode_seq_chk.sv
module mode_seq_chk #(
  parameter int unsigned AG_W = 6,
  localparam int unsigned DATA_W = AG_W + 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              smp_stb,
  input logic              mode_special,
  input logic              load_display,
  input logic              load_bright,
  input logic [DATA_W-1:0] disp_data,
  input logic              bright_hc,
  input logic [AG_W-1:0]   bright_ag,
  input logic [DATA_W-1:0] gain_code
);
  // R5 / R6: one latch pulse goes to at most one destination
  a_r5_single_dest: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({load_display, load_bright}));

  // R6: the display register is never targeted in configuration mode
  a_r6_no_disp_in_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    mode_special |-> !load_display);

  // R9: brightness fields move only after a brightness load
  a_r9_bright_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load_bright |=> ($stable(bright_hc) && $stable(bright_ag)));

  // R8: mode changes only on a strobe
  a_r8_mode_needs_stb: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_stb |=> $stable(mode_special));

  // R3: leaving configuration mode leaves display data at zero
  a_r3_clear_on_exit: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mode_special) |-> (disp_data == '0));

  // R5: display data moves only on a display load or a mode exit
  a_r5_disp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load_display |=> ($stable(disp_data) || $fell(mode_special)));

  // R7: gain stays inside the combined range
  a_r7_gain_range: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_code >= DATA_W'(1 << AG_W)) && (gain_code <= DATA_W'((1 << (AG_W + 2)) - 2)));
endmodule

bind mode_seq_top mode_seq_chk #(.AG_W(AG_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .smp_stb     (smp_stb),
  .mode_special(mode_special),
  .load_display(load_display),
  .load_bright (load_bright),
  .disp_data   (disp_data),
  .bright_hc   (bright_hc),
  .bright_ag   (bright_ag),
  .gain_code   (gain_code)
);

// File: tb/tb_mode_seq_top.sv
`timescale 1ns/1ps
module tb_mode_seq_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       smp_stb;
  logic       en_pin;
  logic       latch_pin;
  logic [7:0] shift_data;
  logic       mode_special, load_display, load_bright;
  logic [7:0] disp_data;
  logic       bright_hc;
  logic [5:0] bright_ag;
  logic [7:0] gain_code;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mode_seq_top dut (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .en_pin(en_pin),
    .latch_pin(latch_pin), .shift_data(shift_data),
    .mode_special(mode_special), .load_display(load_display),
    .load_bright(load_bright), .disp_data(disp_data),
    .bright_hc(bright_hc), .bright_ag(bright_ag), .gain_code(gain_code)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic sample(input logic e, input logic l);
    @(negedge clk);
    en_pin = e; latch_pin = l; smp_stb = 1'b1;
    @(negedge clk);
    smp_stb = 1'b0; latch_pin = 1'b0;
  endtask

  task automatic idle(input logic e, input logic l);
    @(negedge clk);
    en_pin = e; latch_pin = l; smp_stb = 1'b0;
    @(negedge clk);
    latch_pin = 1'b0;
  endtask

  // entry: en 1,0,1,1,1 latch 0,0,0,1,0
  task automatic entry_seq(input bit noisy);
    sample(1, 0); if (noisy) idle(0, 1);
    sample(0, 0); if (noisy) idle(1, 1);
    sample(1, 0); if (noisy) idle(0, 1);
    sample(1, 1); if (noisy) idle(1, 1);
    sample(1, 0);
  endtask

  // exit: en 1,0,1,1,1 latch all 0
  task automatic exit_seq();
    sample(1, 0); sample(0, 0); sample(1, 0); sample(1, 0); sample(1, 0);
  endtask

  function automatic logic [7:0] make_code(input bit hc, input logic [5:0] ag, input bit rsv);
    logic [7:0] c;
    c = 8'h00;
    c[1] = hc;
    c[0] = rsv;
    for (int k = 0; k < 6; k++) c[7-k] = ag[k];
    return c;
  endfunction

  function automatic int exp_gain(input bit hc, input int ag);
    return hc ? 128 + 2 * ag : 64 + ag;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; smp_stb = 0; en_pin = 0; latch_pin = 0; shift_data = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 mode", mode_special, 0);
    chk("R1 disp", disp_data, 0);
    chk("R1 hc", bright_hc, 1);
    chk("R1 ag", bright_ag, 6'h3F);
    chk("R1 gain", gain_code, 254);

    // R5 display load, pulse visible in the strobe cycle
    shift_data = 8'hA5;
    @(negedge clk);
    en_pin = 0; latch_pin = 1; smp_stb = 1;
    #1;
    chk("R5 load_display pulse", load_display, 1);
    chk("R5 load_bright quiet", load_bright, 0);
    @(negedge clk);
    smp_stb = 0; latch_pin = 0;
    chk("R5 disp loaded", disp_data, 8'hA5);

    // R8 latch high without strobe
    shift_data = 8'h3C;
    idle(0, 1);
    chk("R8 no strobe no load", disp_data, 8'hA5);

    // R8 near miss (4th enable differs): not blocked, no entry
    shift_data = 8'h5A;
    sample(1, 0); sample(0, 0); sample(1, 0); sample(0, 1); sample(1, 0);
    chk("R8 near miss mode", mode_special, 0);
    chk("R8 near miss load", disp_data, 8'h5A);

    // R2 entry with noise cycles; R4 blocked prefix latch
    shift_data = 8'hFF;
    entry_seq(1);
    chk("R2 entered", mode_special, 1);
    chk("R4 disp untouched", disp_data, 8'h5A);
    chk("R4 bright untouched", gain_code, 254);

    // R6 / R7 sweep every range bit and step value
    for (int h = 0; h < 2; h++) begin
      for (int a = 0; a < 64; a++) begin
        shift_data = make_code(h[0], a[5:0], a[0] ^ h[0]);
        sample(0, 1);
        chk("R6 hc", bright_hc, h);
        chk("R6 ag", bright_ag, a);
        chk("R7 gain", gain_code, exp_gain(h[0], a));
      end
    end
    chk("R6 disp unchanged", disp_data, 8'h5A);

    // R4 prefix inside configuration mode
    shift_data = make_code(0, 6'h15, 1);
    sample(0, 1);
    shift_data = 8'h02;
    entry_seq(0);
    chk("R4 cfg prefix bright", bright_ag, 6'h15);
    chk("R4 cfg prefix hc", bright_hc, 0);
    chk("R2 stays cfg", mode_special, 1);

    // R3 exit clears display; R9 brightness kept
    exit_seq();
    chk("R3 exited", mode_special, 0);
    chk("R3 disp cleared", disp_data, 0);
    chk("R9 ag kept", bright_ag, 6'h15);
    chk("R9 gain kept", gain_code, 64 + 21);

    // R10 exit pattern in display mode
    shift_data = 8'h77;
    sample(0, 1);
    chk("R5 reload", disp_data, 8'h77);
    exit_seq();
    chk("R10 mode", mode_special, 0);
    chk("R10 disp kept", disp_data, 8'h77);

    // R1 reset again restores defaults
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk("R1 re-reset disp", disp_data, 0);
    chk("R1 re-reset gain", gain_code, 254);
    chk("R1 re-reset hc", bright_hc, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule